// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses over 4 KB pages. It holds sixteen translations and compares every one of them against the lookup address at the same time. A lookup that finds a usable entry returns the physical address at once, in the same cycle. Any other lookup reports a miss. A miss also records the state a software refill routine needs to locate the missing page-table entry.

On a miss the block stores the whole faulting address. It also writes the page number into a context register, whose upper field holds a page-table base that software has set. The context value then points straight at the page-table entry in memory. The handler loads that entry into two staging registers and pulses a write strobe. The block then copies the staged entry into the slot that a free-running counter selects, which replaces an entry without any usage tracking.

Top module: `swtlb_top`

## Requirements
- R1: After reset, every entry is invalid. The replacement counter reads 15, and both the bad-address register and the context register read 0.
- R2: When a lookup's bits 31:12 equal the tag of an entry with its valid flag set, `lk_hit` is 1 in the same cycle. `lk_pa` is then that entry's frame number joined with lookup bits 11:0, and `lk_valid` and `lk_dirty` show the entry's flags.
- R3: A requested lookup is reported as a miss (`lk_miss`=1, `lk_hit`=0) in two cases: no entry's tag matches, or the only matching entry has its valid flag clear.
- R4: After a missed lookup, the bad-address register (register 3, read-only) holds the full 32-bit faulting address from the next clock onward.
- R5: The context register is register 2. Software writes set bits 31:20 only. After a miss, hardware places lookup bits 29:12 into bits 19:2. Bits 1:0 always read 0.
- R6: A lookup that hits leaves the bad-address register and context bits 19:2 unchanged.
- R7: The replacement counter is register 4, read-only, with the value in bits 3:0 and 0 above. It steps down by one on every clock and goes from 0 back to 15.
- R8: Register 0 is the staged tag, with the page number in bits 31:12. Register 1 is the staged frame word: frame number in bits 31:12, dirty flag in bit 1, valid flag in bit 0. Each register reads back exactly what was written. A `wr_rand` pulse copies the staged tag and frame word into the slot the counter shows in that cycle.
- R9: A store lookup (`lk_store`=1) that hits an entry with its dirty flag clear raises `lk_modfault`. A store that hits a dirty entry does not raise it, and neither does a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | A lookup is requested this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_store | input | 1 | The lookup is for a store |
| lk_hit | output | 1 | Translation found in a valid entry |
| lk_pa | output | 32 | Physical address (meaningful on hit) |
| lk_valid | output | 1 | Valid flag of the matching entry |
| lk_dirty | output | 1 | Dirty flag of the matching entry |
| lk_miss | output | 1 | Requested lookup failed |
| lk_modfault | output | 1 | Store hit a clean entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wr_rand | input | 1 | Copy staged entry into the counter-chosen slot |

## Verification
The counter keeps moving on its own, so the bench cannot know in advance which slot a refill will land in. To handle this, the bench reads register 4 in the same cycle that it raises `wr_rand`. It records the entry in its own sixteen-slot model at that index, so whatever gets overwritten is reflected in the expected lookups. The other hard case is a tag that matches but whose valid flag is clear. The bench installs such an entry on purpose and checks that a lookup of it counts as a miss and updates the fault registers.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_BITS  = 12;
    localparam int VPN_W      = VA_W - PAGE_BITS;
    localparam int PFN_W      = 20;
    localparam int ENTRIES    = 16;
    localparam int IDX_W      = $clog2(ENTRIES);
    localparam int CTX_BASE_W = 12;
    localparam int CTX_VPN_W  = VA_W - CTX_BASE_W - 2;
    localparam int RA_W       = 3;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [PFN_W-1:0] pfn;
        logic [VPN_W-1:0] vpn;
    } tlb_entry_t;

    typedef enum logic [RA_W-1:0] {
        RG_TAG  = 3'd0,
        RG_LO   = 3'd1,
        RG_CTX  = 3'd2,
        RG_BAD  = 3'd3,
        RG_RAND = 3'd4
    } reg_sel_e;

    function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] a);
        return a[VA_W-1:PAGE_BITS];
    endfunction
endpackage

// File: rtl/tlbx_rand.sv
module tlbx_rand
    import tlbx_pkg::*;
#(
    parameter int N  = ENTRIES,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] TOP = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst)              idx <= TOP;
        else if (idx == '0)   idx <= TOP;
        else                  idx <= idx - 1'b1;
    end

    // R7
    rand_step_chk: assert property (@(posedge clk) disable iff (rst)
        (idx != '0) |=> (idx == $past(idx) - 1'b1));
    // R7
    rand_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (idx == '0) |=> (idx == TOP));
endmodule

// File: rtl/tlbx_cam.sv
module tlbx_cam
    import tlbx_pkg::*;
#(
    parameter int N  = ENTRIES,
    parameter int IW = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  tlb_entry_t       wentry,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             found,
    output tlb_entry_t       sel
);
    tlb_entry_t      ents [N];
    logic [N-1:0]    mvec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ents[i] <= '0;
        end else if (we) begin
            ents[widx] <= wentry;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign mvec[g] = (ents[g].vpn == look_vpn);
    end

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mvec[i]) begin
                found = 1'b1;
                sel   = ents[i];
            end
        end
    end

    // R8
    slot_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (ents[$past(widx)] == $past(wentry)));
endmodule

// File: rtl/tlbx_regs.sv
module tlbx_regs
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [VA_W-1:0]  reg_wdata,
    input  logic             miss,
    input  logic             hit,
    input  logic [VA_W-1:0]  va,
    input  logic [IDX_W-1:0] rand_idx,
    output tlb_entry_t       staged,
    output logic [VA_W-1:0]  rdata
);
    logic [VA_W-1:0]       st_tag, st_lo, bad;
    logic [CTX_BASE_W-1:0] ctx_base;
    logic [CTX_VPN_W-1:0]  ctx_vpn;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_tag   <= '0;
            st_lo    <= '0;
            bad      <= '0;
            ctx_base <= '0;
            ctx_vpn  <= '0;
        end else begin
            if (reg_wr && reg_addr == RG_TAG) st_tag <= reg_wdata;
            if (reg_wr && reg_addr == RG_LO)  st_lo  <= reg_wdata;
            if (reg_wr && reg_addr == RG_CTX)
                ctx_base <= reg_wdata[VA_W-1 -: CTX_BASE_W];
            if (miss) begin
                bad     <= va;
                ctx_vpn <= va[PAGE_BITS +: CTX_VPN_W];
            end
        end
    end

    always_comb begin
        staged.valid = st_lo[0];
        staged.dirty = st_lo[1];
        staged.pfn   = st_lo[VA_W-1 -: PFN_W];
        staged.vpn   = page_of(st_tag);
    end

    always_comb begin
        case (reg_addr)
            RG_TAG:  rdata = st_tag;
            RG_LO:   rdata = st_lo;
            RG_CTX:  rdata = {ctx_base, ctx_vpn, 2'b00};
            RG_BAD:  rdata = bad;
            RG_RAND: rdata = {{(VA_W-IDX_W){1'b0}}, rand_idx};
            default: rdata = '0;
        endcase
    end

    // R4
    bad_latch_chk: assert property (@(posedge clk) disable iff (rst)
        miss |=> (bad == $past(va)));
    // R6
    hit_keeps_bad_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> ($stable(bad) && $stable(ctx_vpn)));
endmodule

// File: rtl/swtlb_top.sv
module swtlb_top
    import tlbx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_req,
    input  logic [VA_W-1:0] lk_va,
    input  logic            lk_store,
    output logic            lk_hit,
    output logic [VA_W-1:0] lk_pa,
    output logic            lk_valid,
    output logic            lk_dirty,
    output logic            lk_miss,
    output logic            lk_modfault,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [VA_W-1:0] reg_wdata,
    output logic [VA_W-1:0] reg_rdata,
    input  logic            wr_rand
);
    logic [IDX_W-1:0] rand_idx;
    tlb_entry_t       staged, sel;
    logic             found;

    tlbx_rand #(.N(ENTRIES), .IW(IDX_W)) u_rand (
        .clk(clk), .rst(rst), .idx(rand_idx)
    );

    tlbx_cam #(.N(ENTRIES), .IW(IDX_W)) u_cam (
        .clk(clk), .rst(rst), .we(wr_rand), .widx(rand_idx),
        .wentry(staged), .look_vpn(page_of(lk_va)),
        .found(found), .sel(sel)
    );

    tlbx_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .miss(lk_miss), .hit(lk_hit), .va(lk_va),
        .rand_idx(rand_idx), .staged(staged), .rdata(reg_rdata)
    );

    always_comb begin
        lk_hit      = lk_req && found && sel.valid;
        lk_miss     = lk_req && !lk_hit;
        lk_pa       = {sel.pfn, lk_va[PAGE_BITS-1:0]};
        lk_valid    = found && sel.valid;
        lk_dirty    = found && sel.dirty;
        lk_modfault = lk_hit && lk_store && !sel.dirty;
    end

    // R9
    modfault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_modfault |-> (lk_hit && lk_store));
    // R3
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> (lk_hit != lk_miss));
endmodule

// File: tb/sim_swtlb_top.sv
`timescale 1ns/1ps
module sim_swtlb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0, lk_store = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit, lk_valid, lk_dirty, lk_miss, lk_modfault;
    logic [31:0] lk_pa, reg_rdata;
    logic        reg_wr = 1'b0, wr_rand = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic        m_v [16];
    logic        m_d [16];
    logic [19:0] m_vpn [16];
    logic [19:0] m_pfn [16];
    logic [31:0] m_bad = '0;
    logic [11:0] m_base = '0;
    logic [17:0] m_cvpn = '0;

    always #2.5 clk = ~clk;

    swtlb_top u0 (.*);

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic put_entry(input logic [19:0] vpn, input logic [19:0] pfn, input bit v, input bit d);
        logic [31:0] r, slot;
        wr(3'd0, {vpn, 12'h000});
        rd(3'd0, r);
        chk(r == {vpn, 12'h000}, "R8 staged tag readback", r, {vpn, 12'h000});
        wr(3'd1, {pfn, 10'h000, d, v});
        rd(3'd1, r);
        chk(r == {pfn, 10'h000, d, v}, "R8 staged frame readback", r, {pfn, 10'h000, d, v});
        rd(3'd4, slot);
        wr_rand = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_rand = 1'b0;
        m_v[slot[3:0]] = v; m_d[slot[3:0]] = d;
        m_vpn[slot[3:0]] = vpn; m_pfn[slot[3:0]] = pfn;
    endtask

    task automatic look(input logic [31:0] va, input bit st, input string tag);
        bit f; int k; bit eh;
        f = 1'b0; k = 0;
        for (int i = 15; i >= 0; i--) if (m_vpn[i] == va[31:12]) begin f = 1'b1; k = i; end
        eh = f && m_v[k];
        lk_req = 1'b1; lk_va = va; lk_store = st;
        #1;
        chk(lk_hit == eh, {tag, " hit"}, 32'(lk_hit), 32'(eh));
        chk(lk_miss == !eh, {tag, " miss"}, 32'(lk_miss), 32'(!eh));
        if (eh) begin
            chk(lk_pa == {m_pfn[k], va[11:0]}, {tag, " pa"}, lk_pa, {m_pfn[k], va[11:0]});
            chk(lk_dirty == m_d[k] && lk_valid, {tag, " flags"}, {30'd0, lk_valid, lk_dirty}, {30'd0, 1'b1, m_d[k]});
        end
        chk(lk_modfault == (eh && st && !m_d[k]), {tag, " R9 modfault"},
            32'(lk_modfault), 32'(eh && st && !m_d[k]));
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0; lk_store = 1'b0;
        if (!eh) begin m_bad = va; m_cvpn = va[29:12]; end
    endtask

    task automatic chk_fault_regs(input string tag);
        logic [31:0] r;
        rd(3'd3, r);
        chk(r == m_bad, {tag, " bad"}, r, m_bad);
        rd(3'd2, r);
        chk(r == {m_base, m_cvpn, 2'b00}, {tag, " ctx"}, r, {m_base, m_cvpn, 2'b00});
    endtask

    task automatic t_reset;
        logic [31:0] r;
        rd(3'd4, r);
        chk(r == 32'd15, "R1 counter at reset", r, 32'd15);
        chk_fault_regs("R1 reset");
        look(32'h0000_0123, 1'b0, "R1 empty lookup");
    endtask

    task automatic t_rand;
        logic [31:0] a, b;
        bit wrapped;
        wrapped = 1'b0;
        for (int n = 0; n < 20; n++) begin
            rd(3'd4, a);
            @(posedge clk); @(negedge clk);
            rd(3'd4, b);
            chk(b == ((a == 0) ? 32'd15 : a - 1), "R7 counter step", b, (a == 0) ? 32'd15 : a - 1);
            if (a == 0) wrapped = 1'b1;
        end
        chk(wrapped, "R7 wrap seen", 32'(wrapped), 32'd1);
    endtask

    task automatic t_fill;
        put_entry(20'h12345, 20'hABCDE, 1'b1, 1'b1);
        put_entry(20'h00042, 20'h11111, 1'b1, 1'b0);
        put_entry(20'h7FFFF, 20'h22222, 1'b0, 1'b1);
        put_entry(20'hC0DE0, 20'h33333, 1'b1, 1'b1);
    endtask

    task automatic t_miss;
        look(32'hDEAD_0123, 1'b0, "R3 no match");
        chk_fault_regs("R4 R5 after miss");
        look(32'h7FFF_F800, 1'b0, "R3 invalid match");
        chk_fault_regs("R4 R5 after invalid");
    endtask

    task automatic t_ctx;
        wr(3'd2, 32'hFFFF_FFFF);
        m_base = 12'hFFF;
        chk_fault_regs("R5 base write");
        wr(3'd2, 32'h5A50_0003);
        m_base = 12'h5A5;
        chk_fault_regs("R5 base rewrite");
    endtask

    task automatic t_hit;
        look(32'h1234_5ABC, 1'b0, "R2 hit dirty");
        look(32'h0004_2FFF, 1'b0, "R2 hit clean");
        look(32'hC0DE_0000, 1'b0, "R2 hit top");
        chk_fault_regs("R6 after hits");
    endtask

    task automatic t_mod;
        look(32'h0004_2010, 1'b1, "R9 store clean");
        look(32'h1234_5010, 1'b1, "R9 store dirty");
        look(32'h0004_2020, 1'b0, "R9 load clean");
        chk_fault_regs("R6 after stores");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_d[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_rand;
        t_fill;
        t_miss;
        t_ctx;
        t_hit;
        t_mod;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule